// File: doc/BRIEF.md
# Three-plane color matrix converter

This block maps each incoming pixel through a 3x3 matrix of signed fixed-point weights and adds a per-plane signed offset. It is the arithmetic core of a color space conversion. Pixels arrive on a valid/ready stream, one per beat, with all three color planes packed into a single word. Each beat leaves as three full-precision signed results. Those results are wide enough that no weight, offset or sample value can overflow them. Turning them into output integers (scaling, rounding, clamping) is the job of a later block.

Each weight and offset is a two's complement value of `CW` bits, of which `CFRAC` are fractional. Because a sample is an integer, each result carries `CFRAC` fractional bits.

The weights and offsets can come from two places:
- **Run-time mode:** software writes them over a simple register port into a shadow set. A commit write makes the shadow set active. The block stops taking pixels until its pipeline is empty and only then swaps the sets, so every pixel is computed with one consistent matrix.
- **Fixed mode:** the active set comes from parameters and the register port is ignored.

Top module: `csc_matrix`

## Requirements
- R1: Input plane j occupies `in_data[j*DW +: DW]` as an unsigned integer (plane 0 in the least significant bits; for DW=8 that is bits 7:0, 15:8, 23:16). Output plane k occupies `out_data[k*RW +: RW]` as a two's complement value, where RW = CW+DW+3.
- R2: Output plane k equals `W[3*0+k]*in0 + W[3*1+k]*in1 + W[3*2+k]*in2 + OFS[k]`, computed exactly. Here W and OFS are the active signed weights and offsets. No overflow occurs for any weight, offset or sample value.
- R3: With `out_ready` held high, a pixel accepted on clock edge P appears with `out_valid` high after edge P+2. That is three clock edges of latency, including the accepting edge.
- R4: While `out_valid` is high and `out_ready` is low, the output beat is held unchanged and `in_ready` is low. Every accepted pixel leaves exactly once and in order.
- R5: In run-time mode, a write to address a (0..8) sets shadow weight W[a], and a write to address 9+k sets shadow offset OFS[k]. Shadow writes do not change results until a commit.
- R6: A write to address 12 requests a commit. From the next cycle `in_ready` is low until the pipeline is empty, and then the shadow set becomes active in one step. Pixels accepted on or before the commit-write edge use the old set; later pixels use the new set.
- R7: After reset, `out_valid` is low and `in_ready` is high. In run-time mode all shadow and active weights and offsets reset to zero; the parameter defaults are not used.
- R8: In fixed mode (`RUNTIME_CTRL`=0), the active set equals `DEF_COEF`/`DEF_OFFSET` from reset onward, and register writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block accepts a pixel this cycle |
| in_data | input | 3*DW | Packed pixel, plane 0 in LSBs |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Downstream accepts the result |
| out_data | output | 3*RW | Packed signed results, plane 0 in LSBs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (0..8 weights, 9..11 offsets, 12 commit) |
| reg_wdata | input | CW | Register write data |

## Verification
A wrong internal state in this datapath shows up as a mismatch on the first result beat that passes through it. Three cases cover it:
- **Corrupted product or partial sum:** the wrong value reaches `out_data` within three edges of the pixel's acceptance.
- **Lost or duplicated stage valid:** the output stream has a missing or extra beat against the per-pixel scoreboard, and outstanding entries remain when the stream drains.
- **Commit taken with a pixel in flight, or with shadow values leaking early:** the pixels around the commit come out computed with the wrong matrix. So every pixel on both sides of a mid-stream commit is compared, under random backpressure.

// File: rtl/csc_pkg.sv
package csc_pkg;

    localparam int NUM_PLANES  = 3;
    localparam int NUM_COEF    = NUM_PLANES * NUM_PLANES;
    localparam int REG_ADDR_W  = 4;
    localparam int OFS_BASE    = NUM_COEF;
    localparam int COMMIT_ADDR = OFS_BASE + NUM_PLANES;

endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank
    import csc_pkg::*;
#(
    parameter int CW                     = 16,
    parameter bit RUNTIME_CTRL           = 1'b1,
    parameter int DEF_COEF [NUM_COEF]    = '{default: 0},
    parameter int DEF_OFFSET [NUM_PLANES] = '{default: 0}
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               reg_we,
    input  logic [REG_ADDR_W-1:0]              reg_addr,
    input  logic [CW-1:0]                      reg_wdata,
    input  logic                               pipe_empty,
    output logic [NUM_COEF-1:0][CW-1:0]        coef,
    output logic [NUM_PLANES-1:0][CW-1:0]      offset,
    output logic                               commit_pending
);

    typedef struct packed {
        logic [NUM_COEF-1:0][CW-1:0]   sh_coef;
        logic [NUM_COEF-1:0][CW-1:0]   act_coef;
        logic [NUM_PLANES-1:0][CW-1:0] sh_ofs;
        logic [NUM_PLANES-1:0][CW-1:0] act_ofs;
        logic                          pending;
    } bank_t;

    function automatic bank_t reset_value();
        bank_t v;
        v = '0;
        if (!RUNTIME_CTRL) begin
            for (int i = 0; i < NUM_COEF; i++) v.act_coef[i] = CW'(DEF_COEF[i]);
            for (int k = 0; k < NUM_PLANES; k++) v.act_ofs[k] = CW'(DEF_OFFSET[k]);
        end
        return v;
    endfunction

    localparam bank_t RESET_VAL = reset_value();

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (RUNTIME_CTRL) begin
            // swap only once every in-flight pixel has left the pipeline
            if (st_q.pending && pipe_empty) begin
                st_d.act_coef = st_q.sh_coef;
                st_d.act_ofs  = st_q.sh_ofs;
                st_d.pending  = 1'b0;
            end
            if (reg_we) begin
                for (int i = 0; i < NUM_COEF; i++) begin
                    if (reg_addr == REG_ADDR_W'(i)) st_d.sh_coef[i] = reg_wdata;
                end
                for (int k = 0; k < NUM_PLANES; k++) begin
                    if (reg_addr == REG_ADDR_W'(OFS_BASE + k)) st_d.sh_ofs[k] = reg_wdata;
                end
                if (reg_addr == REG_ADDR_W'(COMMIT_ADDR)) st_d.pending = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RESET_VAL;
        else        st_q <= st_d;
    end

    assign coef           = st_q.act_coef;
    assign offset         = st_q.act_ofs;
    assign commit_pending = st_q.pending;

    // R6: the active set may only change after a cycle with an empty pipeline
    a_r6_swap_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({st_q.act_coef, st_q.act_ofs}) |-> $past(pipe_empty));

endmodule

// File: rtl/csc_mac_pipe.sv
module csc_mac_pipe
    import csc_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 16,
    parameter int PW = CW + DW + 1,
    parameter int RW = PW + 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    output logic                               in_ready,
    input  logic [NUM_PLANES*DW-1:0]           in_data,
    input  logic                               accept_en,
    input  logic [NUM_COEF-1:0][CW-1:0]        coef,
    input  logic [NUM_PLANES-1:0][CW-1:0]      offset,
    output logic                               out_valid,
    input  logic                               out_ready,
    output logic [NUM_PLANES*RW-1:0]           out_data,
    output logic                               empty
);

    typedef struct packed {
        logic                          v1;
        logic                          v2;
        logic                          v3;
        logic [NUM_COEF-1:0][PW-1:0]   prod;
        logic [NUM_PLANES-1:0][RW-1:0] part;
        logic [NUM_PLANES-1:0][RW-1:0] res;
    } pipe_t;

    function automatic logic [PW-1:0] mul_sample(input logic [CW-1:0] c, input logic [DW-1:0] x);
        logic signed [PW-1:0] cs;
        logic signed [PW-1:0] xs;
        cs = PW'($signed(c));
        xs = $signed(PW'(x));
        return cs * xs;
    endfunction

    function automatic logic [RW-1:0] ext_prod(input logic [PW-1:0] p);
        return RW'($signed(p));
    endfunction

    function automatic logic [RW-1:0] ext_ofs(input logic [CW-1:0] o);
        return RW'($signed(o));
    endfunction

    pipe_t st_d, st_q;
    logic  advance;
    logic  take;

    assign advance  = !st_q.v3 || out_ready;
    assign in_ready = advance && accept_en;
    assign take     = in_valid && in_ready;

    always_comb begin
        st_d = st_q;
        if (advance) begin
            st_d.v1 = take;
            st_d.v2 = st_q.v1;
            st_d.v3 = st_q.v2;
            // stage 1: nine products
            if (take) begin
                for (int j = 0; j < NUM_PLANES; j++) begin
                    for (int k = 0; k < NUM_PLANES; k++) begin
                        st_d.prod[NUM_PLANES*j+k] =
                            mul_sample(coef[NUM_PLANES*j+k], in_data[j*DW +: DW]);
                    end
                end
            end
            // stage 2: sum of the three products per output plane
            if (st_q.v1) begin
                for (int k = 0; k < NUM_PLANES; k++) begin
                    st_d.part[k] = ext_prod(st_q.prod[k])
                                 + ext_prod(st_q.prod[NUM_PLANES+k])
                                 + ext_prod(st_q.prod[2*NUM_PLANES+k]);
                end
            end
            // stage 3: offset
            if (st_q.v2) begin
                for (int k = 0; k < NUM_PLANES; k++) begin
                    st_d.res[k] = st_q.part[k] + ext_ofs(offset[k]);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.v3;
    assign out_data  = st_q.res;
    assign empty     = !st_q.v1 && !st_q.v2 && !st_q.v3;

    // R4: a stalled beat stays put
    a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R4: no new pixel enters while the output is stalled
    a_r4_no_take_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

endmodule

// File: rtl/csc_matrix.sv
module csc_matrix
    import csc_pkg::*;
#(
    parameter int DW                      = 8,
    parameter int CW                      = 16,
    parameter int CFRAC                   = 12,
    parameter bit RUNTIME_CTRL            = 1'b1,
    parameter int DEF_COEF [NUM_COEF]     = '{1 << CFRAC, 0, 0, 0, 1 << CFRAC, 0, 0, 0, 1 << CFRAC},
    parameter int DEF_OFFSET [NUM_PLANES] = '{0, 0, 0},
    localparam int PW = CW + DW + 1,
    localparam int RW = PW + 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [NUM_PLANES*DW-1:0]  in_data,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [NUM_PLANES*RW-1:0]  out_data,
    input  logic                      reg_we,
    input  logic [REG_ADDR_W-1:0]     reg_addr,
    input  logic [CW-1:0]             reg_wdata
);

    logic [NUM_COEF-1:0][CW-1:0]   coef;
    logic [NUM_PLANES-1:0][CW-1:0] offset;
    logic                          commit_pending;
    logic                          pipe_empty;

    csc_coef_bank #(
        .CW           (CW),
        .RUNTIME_CTRL (RUNTIME_CTRL),
        .DEF_COEF     (DEF_COEF),
        .DEF_OFFSET   (DEF_OFFSET)
    ) i_bank (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_we         (reg_we),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .pipe_empty     (pipe_empty),
        .coef           (coef),
        .offset         (offset),
        .commit_pending (commit_pending)
    );

    csc_mac_pipe #(
        .DW (DW),
        .CW (CW),
        .PW (PW),
        .RW (RW)
    ) i_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .accept_en (!commit_pending),
        .coef      (coef),
        .offset    (offset),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .empty     (pipe_empty)
    );

    // R6: input is closed while a commit waits for the pipeline to drain
    a_r6_closed_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
        commit_pending |-> !in_ready);

endmodule

// File: tb/test_csc_matrix.sv
module test_csc_matrix;

    localparam int CLK_PERIOD = 10;
    localparam int DW    = 8;
    localparam int CW    = 16;
    localparam int CFRAC = 12;
    localparam int RW    = CW + DW + 3;
    localparam int ONE   = 1 << CFRAC;
    localparam int S_COEF [9] = '{4096, 1024, 0, -2048, 4096, 0, 0, 512, 8192};
    localparam int S_OFS  [3] = '{100, -200, 0};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [3*DW-1:0] in_data = '0;
    logic            out_valid;
    logic            out_ready = 1'b1;
    logic [3*RW-1:0] out_data;
    logic            reg_we = 1'b0;
    logic [3:0]      reg_addr = '0;
    logic [CW-1:0]   reg_wdata = '0;
    logic            s_in_valid = 1'b0;
    logic            s_in_ready;
    logic [3*DW-1:0] s_in_data = '0;
    logic            s_out_valid;
    logic [3*RW-1:0] s_out_data;

    int    n_checks = 0;
    int    n_err    = 0;
    bit    bp_en    = 1'b0;
    bit    done     = 1'b0;
    string cur_req  = "R7";

    longint m_sh_c [9];
    longint m_act_c[9];
    longint m_sh_o [3];
    longint m_act_o[3];
    longint e0[$], e1[$], e2[$];
    bit              prev_stall = 1'b0;
    logic [3*RW-1:0] prev_data  = '0;

    csc_matrix #(.DW(DW), .CW(CW), .CFRAC(CFRAC)) i_csc_matrix (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata));

    csc_matrix #(.DW(DW), .CW(CW), .CFRAC(CFRAC), .RUNTIME_CTRL(1'b0),
                 .DEF_COEF(S_COEF), .DEF_OFFSET(S_OFS)) i_csc_matrix_static (
        .clk(clk), .rst_n(rst_n), .in_valid(s_in_valid), .in_ready(s_in_ready),
        .in_data(s_in_data), .out_valid(s_out_valid), .out_ready(1'b1),
        .out_data(s_out_data), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata));

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        #1;
        out_ready = bp_en ? ($urandom_range(0, 3) != 0) : 1'b1;
    end

    task automatic check(input bit ok, input string msg);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s", msg);
        end
    endtask

    function automatic longint plane_of(input logic [3*RW-1:0] d, input int k);
        logic signed [RW-1:0] t;
        t = d[k*RW +: RW];
        return longint'(t);
    endfunction

    function automatic longint model_plane(input int k, input logic [3*DW-1:0] pix);
        longint s;
        s = m_act_o[k];
        for (int j = 0; j < 3; j++) s += m_act_c[3*j+k] * longint'(pix[j*DW +: DW]);
        return s;
    endfunction

    // scoreboard: sampled mid-cycle, values hold for the next rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (prev_stall)
                check(out_valid && out_data == prev_data,
                      $sformatf("R4 stalled beat changed: actual %h expected %h", out_data, prev_data));
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            if (in_valid && in_ready) begin
                e0.push_back(model_plane(0, in_data));
                e1.push_back(model_plane(1, in_data));
                e2.push_back(model_plane(2, in_data));
            end
            if (out_valid && out_ready) begin
                if (e0.size() == 0) begin
                    check(1'b0, $sformatf("R4 extra beat: actual %h expected none", out_data));
                end else begin
                    longint x0, x1, x2;
                    x0 = e0.pop_front(); x1 = e1.pop_front(); x2 = e2.pop_front();
                    check(plane_of(out_data, 0) == x0,
                          $sformatf("%s plane0: actual %0d expected %0d", cur_req, plane_of(out_data, 0), x0));
                    check(plane_of(out_data, 1) == x1,
                          $sformatf("%s plane1: actual %0d expected %0d", cur_req, plane_of(out_data, 1), x1));
                    check(plane_of(out_data, 2) == x2,
                          $sformatf("%s plane2: actual %0d expected %0d", cur_req, plane_of(out_data, 2), x2));
                end
            end
            if (reg_we) begin
                if (reg_addr < 4'd9)       m_sh_c[reg_addr] = longint'($signed(reg_wdata));
                else if (reg_addr < 4'd12) m_sh_o[reg_addr - 4'd9] = longint'($signed(reg_wdata));
                else if (reg_addr == 4'd12) begin
                    m_act_c = m_sh_c;
                    m_act_o = m_sh_o;
                end
            end
        end
    end

    task automatic wr(input int addr, input longint val);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = addr[3:0]; reg_wdata = val[CW-1:0];
        @(posedge clk); #1;
        reg_we = 1'b0;
        if (addr == 12) begin
            @(negedge clk);
            check(!in_ready, $sformatf("R6 in_ready after commit: actual %0b expected 0", in_ready));
        end
    endtask

    task automatic load_matrix(input longint c[9], input longint o[3]);
        for (int i = 0; i < 9; i++) wr(i, c[i]);
        for (int k = 0; k < 3; k++) wr(9 + k, o[k]);
        wr(12, 0);
    endtask

    task automatic push_pix(input logic [3*DW-1:0] d);
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = d;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic wait_drain();
        int n;
        n = 0;
        while (e0.size() != 0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(e0.size() == 0, $sformatf("R4 beats lost: actual %0d outstanding expected 0", e0.size()));
    endtask

    task automatic t_reset();
        cur_req = "R7";
        @(negedge clk);
        check(!out_valid, $sformatf("R7 out_valid: actual %0b expected 0", out_valid));
        check(in_ready, $sformatf("R7 in_ready: actual %0b expected 1", in_ready));
        check(!s_out_valid, $sformatf("R7 static out_valid: actual %0b expected 0", s_out_valid));
        push_pix(24'h112233);
        push_pix(24'hFFFFFF);
        wait_drain();
    endtask

    task automatic t_packing();
        longint c[9];
        longint o[3];
        c = '{default: 0};
        o = '{default: 0};
        c[0] = ONE; c[4] = 2 * ONE; c[8] = -ONE;
        load_matrix(c, o);
        cur_req = "R1";
        push_pix(24'h302010);
        push_pix(24'h0000FF);
        push_pix(24'hFF0000);
        wait_drain();
    endtask

    task automatic t_latency();
        cur_req = "R3";
        bp_en = 1'b0;
        wait_drain();
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = 24'h405060;
        @(negedge clk);
        check(in_ready, $sformatf("R3 in_ready idle: actual %0b expected 1", in_ready));
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(negedge clk);
        check(!out_valid, $sformatf("R3 edge+0: out_valid actual %0b expected 0", out_valid));
        @(negedge clk);
        check(!out_valid, $sformatf("R3 edge+1: out_valid actual %0b expected 0", out_valid));
        @(negedge clk);
        check(out_valid, $sformatf("R3 edge+2: out_valid actual %0b expected 1", out_valid));
        wait_drain();
    endtask

    task automatic t_stream();
        longint c[9];
        longint o[3];
        logic signed [15:0] r;
        for (int i = 0; i < 9; i++) begin r = 16'($urandom); c[i] = r; end
        for (int k = 0; k < 3; k++) begin r = 16'($urandom); o[k] = r; end
        load_matrix(c, o);
        cur_req = "R2";
        bp_en = 1'b1;
        for (int n = 0; n < 60; n++) push_pix(24'($urandom));
        wait_drain();
        c = '{default: -32768};
        o = '{default: -32768};
        load_matrix(c, o);
        push_pix(24'hFFFFFF);
        push_pix(24'h000000);
        c = '{default: 32767};
        o = '{default: 32767};
        load_matrix(c, o);
        push_pix(24'hFFFFFF);
        push_pix(24'h01FF80);
        wait_drain();
        bp_en = 1'b0;
    endtask

    task automatic t_shadow();
        longint c[9];
        longint o[3];
        c = '{1229, -691, 2048, 2404, -1357, -1715, 467, 2048, -333};
        o = '{0, 64 * ONE, 128 * ONE};
        load_matrix(c, o);
        cur_req = "R5";
        for (int i = 0; i < 9; i++) wr(i, 100 + i);
        for (int k = 0; k < 3; k++) wr(9 + k, -5);
        bp_en = 1'b1;
        for (int n = 0; n < 10; n++) push_pix(24'($urandom));
        wait_drain();
        bp_en = 1'b0;
    endtask

    task automatic t_commit_midstream();
        longint c[9];
        longint o[3];
        cur_req = "R6";
        bp_en = 1'b1;
        c = '{-ONE, ONE / 2, 3, 77, ONE, -900, 12, 0, ONE};
        o = '{-1000, 2000, 7};
        fork
            for (int n = 0; n < 40; n++) push_pix(24'($urandom));
            begin
                repeat (12) @(posedge clk);
                load_matrix(c, o);
            end
        join
        wait_drain();
        bp_en = 1'b0;
    endtask

    task automatic static_pix(input logic [3*DW-1:0] d);
        longint x;
        @(posedge clk); #1;
        s_in_valid = 1'b1; s_in_data = d;
        @(negedge clk);
        check(s_in_ready, $sformatf("R8 static in_ready: actual %0b expected 1", s_in_ready));
        @(posedge clk); #1;
        s_in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check(s_out_valid, $sformatf("R8 static out_valid: actual %0b expected 1", s_out_valid));
        for (int k = 0; k < 3; k++) begin
            x = S_OFS[k];
            for (int j = 0; j < 3; j++) x += longint'(S_COEF[3*j+k]) * longint'(d[j*DW +: DW]);
            check(plane_of(s_out_data, k) == x,
                  $sformatf("R8 static plane%0d: actual %0d expected %0d", k, plane_of(s_out_data, k), x));
        end
    endtask

    task automatic t_static();
        cur_req = "R8";
        static_pix(24'h804020);
        wr(0, -1); wr(4, 0); wr(9, 555); wr(12, 0);
        repeat (4) @(posedge clk);
        static_pix(24'hFF10C3);
    endtask

    task automatic report();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        m_sh_c = '{default: 0}; m_act_c = '{default: 0};
        m_sh_o = '{default: 0}; m_act_o = '{default: 0};
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_packing();
        t_latency();
        t_stream();
        t_shadow();
        t_commit_midstream();
        t_static();
        report();
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

endmodule